// File: doc/BRIEF.md
# Interrupt Status and Register Paging Controller

This block is one 16-bit control/status word inside an audio codec's register file. It records interrupting events in a status flag. Software clears the flag by writing a one to it. Two read-only cause bits tell software which source raised the event: a GPIO status change, or sense activity. An enable bit decides whether the flag reaches the interrupt bit that leaves on the serial link.

The same word launches and aborts a sense cycle run by an external sense engine. The cycle ends when that engine reports completion. The word also holds a page selector, which chooses the bank that appears in the 0x60–0x6F register window.

Every register write updates all writable fields at once. Page numbers at or above the implemented page count are refused. Software that probes pages by writing a number and reading it back therefore sees a mismatch for a page that does not exist. Implemented pages always start at 0 and are contiguous.

Top module: `irq_page_ctrl`

## Requirements
- R1: After reset, the read word, `irqOut`, `senseStart`, `senseAbort` and `pageSel` are all 0.
- R2: A `gpioEvent` pulse sets the status flag (bit 15) and cause bit 13. A `senseEvent` pulse sets the status flag and cause bit 12. Both take effect at the next clock edge, whatever the enable bit holds.
- R3: A write with bit 15 = 1 clears the status flag and both cause bits at the next edge. A write with bit 15 = 0 leaves them unchanged. Whenever the status flag reads 1, at least one cause bit reads 1.
- R4: If an event arrives in the same cycle as a clearing write, the event wins: the status flag stays 1 and the new cause bit is set, while a cause bit with no event that cycle is cleared.
- R5: Writing bit 11 = 1 while no sense cycle runs sets bit 11. It also raises `senseStart` for exactly one cycle, in the cycle after the write. Writing 1 while a cycle already runs keeps bit 11 at 1 and gives no pulse.
- R6: Writing bit 11 = 0 while a cycle runs clears bit 11. It also raises `senseAbort` for exactly one cycle, in the cycle after the write. Writing 0 while idle has no effect.
- R7: `senseDone` while a cycle runs clears bit 11 and sets cause bit 12 and the status flag. In that cycle, completion takes priority over any write to bit 11: no start and no abort pulse follows. `senseDone` while idle is ignored.
- R8: `irqOut` is 1 exactly when the status flag and the enable bit (bit 10, written on every write) are both 1.
- R9: A write whose bits 3:0 hold a value below `NUM_PAGES` loads the page selector (bits 3:0 and `pageSel`). Any other value is ignored, so the page read back differs from the value written.
- R10: Bits 14 and 9:4 always read 0. Writes to them, and to the read-only bits 13 and 12, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | One-cycle write strobe for this register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Current register contents |
| gpioEvent | input | 1 | GPIO status change pulse |
| senseEvent | input | 1 | New sense information pulse |
| senseDone | input | 1 | Sense engine completion pulse |
| irqOut | output | 1 | Masked interrupt toward the link GPI bit |
| senseStart | output | 1 | One-cycle sense cycle launch |
| senseAbort | output | 1 | One-cycle sense cycle abort |
| pageSel | output | 4 | Current page for the 0x60–0x6F window |

## Verification
The assertions assume that `regWrEn`, `gpioEvent`, `senseEvent` and `senseDone` are single-cycle strobes, synchronous to `clk` and never unknown after reset. They also assume `NUM_PAGES` lies between 1 and 16.

The bench drives every input at the falling edge and releases each strobe after one cycle. It applies `senseDone` both inside and outside a running cycle. It sweeps all sixteen page values and every combination of the two events, the clear bit and the enable bit. This keeps the stimulus inside those assumptions while still reaching every same-cycle collision.

// File: rtl/irq_page_pkg.sv
package irq_page_pkg;

  localparam int REG_W       = 16;
  localparam int PAGE_FIELD_W = 4;

  // Bit positions decoded by software; fixed by the register layout.
  localparam int STATUS_BIT     = 15;
  localparam int GPIO_CAUSE_BIT = 13;
  localparam int SENSE_CAUSE_BIT = 12;
  localparam int SENSE_CTL_BIT  = 11;
  localparam int IRQ_EN_BIT     = 10;

  // Strobes from the control decode to the datapath registers.
  typedef struct packed {
    logic clrStatus;   // write-one-to-clear on the status flag
    logic gpioHit;     // record a GPIO cause
    logic senseHit;    // record a sense cause (event or completion)
    logic senseFinish; // running sense cycle has completed
    logic senseGo;     // launch a sense cycle
    logic senseStop;   // abort the running sense cycle
    logic enLoad;      // load the interrupt enable
    logic enVal;       // value for the interrupt enable
    logic pageLoad;    // page number accepted
  } ctlStrobes_t;

endpackage

// File: rtl/irq_page_ctl.sv
module irq_page_ctl
  import irq_page_pkg::*;
#(
  parameter int NUM_PAGES = 2
) (
  input  logic                    regWrEn,
  input  logic                    wrClr,
  input  logic                    wrSense,
  input  logic                    wrEn,
  input  logic [PAGE_FIELD_W-1:0] wrPage,
  input  logic                    gpioEvent,
  input  logic                    senseEvent,
  input  logic                    senseDone,
  input  logic                    senseBusy,
  output ctlStrobes_t             stb
);

  localparam int PAGE_CNT_W = PAGE_FIELD_W + 1;
  localparam logic [PAGE_CNT_W-1:0] PAGE_LIMIT = PAGE_CNT_W'(NUM_PAGES);

  logic finish;
  logic pageOk;

  always_comb begin
    finish = senseDone & senseBusy;
    pageOk = ({1'b0, wrPage} < PAGE_LIMIT);

    stb.clrStatus   = regWrEn & wrClr;
    stb.gpioHit     = gpioEvent;
    stb.senseHit    = senseEvent | finish;
    stb.senseFinish = finish;
    // Completion outranks any same-cycle write to the sense control.
    stb.senseGo     = regWrEn & wrSense & ~senseBusy & ~finish;
    stb.senseStop   = regWrEn & ~wrSense & senseBusy & ~finish;
    stb.enLoad      = regWrEn;
    stb.enVal       = wrEn;
    stb.pageLoad    = regWrEn & pageOk;
  end

endmodule

// File: rtl/irq_page_dp.sv
module irq_page_dp
  import irq_page_pkg::*;
#(
  parameter int NUM_PAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStrobes_t             stb,
  input  logic [PAGE_FIELD_W-1:0] wrPage,
  output logic                    status,
  output logic                    causeGpio,
  output logic                    causeSense,
  output logic                    senseBusy,
  output logic                    irqEn,
  output logic [PAGE_FIELD_W-1:0] page,
  output logic                    startQ,
  output logic                    abortQ
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= 1'b0;
      causeGpio  <= 1'b0;
      causeSense <= 1'b0;
      senseBusy  <= 1'b0;
      irqEn      <= 1'b0;
      page       <= '0;
      startQ     <= 1'b0;
      abortQ     <= 1'b0;
    end else begin
      // New events outrank a same-cycle clear.
      status     <= (status & ~stb.clrStatus) | stb.gpioHit | stb.senseHit;
      causeGpio  <= (causeGpio & ~stb.clrStatus) | stb.gpioHit;
      causeSense <= (causeSense & ~stb.clrStatus) | stb.senseHit;
      if (stb.senseFinish || stb.senseStop) begin
        senseBusy <= 1'b0;
      end else if (stb.senseGo) begin
        senseBusy <= 1'b1;
      end
      if (stb.enLoad) begin
        irqEn <= stb.enVal;
      end
      if (stb.pageLoad) begin
        page <= wrPage;
      end
      startQ <= stb.senseGo;
      abortQ <= stb.senseStop;
    end
  end

  // R3: a set status flag always carries a cause.
  assert_cause_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> (causeGpio || causeSense));

  // R3: a clear with no competing event empties flag and causes.
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrStatus && !stb.gpioHit && !stb.senseHit) |=> (!status && !causeGpio && !causeSense));

  // R2: a GPIO event is recorded at the next edge.
  assert_gpio_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.gpioHit |=> (status && causeGpio));

  // R4: an event colliding with a clear survives it.
  assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrStatus && stb.senseHit) |=> (status && causeSense));

  // R5: a launch pulse is accompanied by a running cycle.
  assert_start_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    startQ |-> senseBusy);

  // R6: an abort pulse follows a running cycle and leaves it stopped.
  assert_abort_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abortQ |-> (!senseBusy && $past(senseBusy)));

  // R7: completion ends the cycle and records a sense cause.
  assert_finish_records_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.senseFinish |=> (!senseBusy && causeSense && status && !startQ && !abortQ));

  // R9: the selector never holds an unimplemented page.
  assert_page_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(page) < NUM_PAGES);

endmodule

// File: rtl/irq_page_ctrl.sv
module irq_page_ctrl
  import irq_page_pkg::*;
#(
  parameter int NUM_PAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        gpioEvent,
  input  logic        senseEvent,
  input  logic        senseDone,
  output logic        irqOut,
  output logic        senseStart,
  output logic        senseAbort,
  output logic [3:0]  pageSel
);

  ctlStrobes_t             stb;
  logic                    status;
  logic                    causeGpio;
  logic                    causeSense;
  logic                    senseBusy;
  logic                    irqEn;
  logic [PAGE_FIELD_W-1:0] page;
  logic                    unusedWrBits;

  // Reserved and read-only positions are not decoded on write.
  assign unusedWrBits = ^{regWrData[14:12], regWrData[9:4]};

  irq_page_ctl #(.NUM_PAGES(NUM_PAGES)) ctl_i (
    .regWrEn    (regWrEn),
    .wrClr      (regWrData[STATUS_BIT]),
    .wrSense    (regWrData[SENSE_CTL_BIT]),
    .wrEn       (regWrData[IRQ_EN_BIT]),
    .wrPage     (regWrData[PAGE_FIELD_W-1:0]),
    .gpioEvent  (gpioEvent),
    .senseEvent (senseEvent),
    .senseDone  (senseDone),
    .senseBusy  (senseBusy),
    .stb        (stb)
  );

  irq_page_dp #(.NUM_PAGES(NUM_PAGES)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wrPage     (regWrData[PAGE_FIELD_W-1:0]),
    .status     (status),
    .causeGpio  (causeGpio),
    .causeSense (causeSense),
    .senseBusy  (senseBusy),
    .irqEn      (irqEn),
    .page       (page),
    .startQ     (senseStart),
    .abortQ     (senseAbort)
  );

  always_comb begin
    regRdData                  = '0;
    regRdData[STATUS_BIT]      = status;
    regRdData[GPIO_CAUSE_BIT]  = causeGpio;
    regRdData[SENSE_CAUSE_BIT] = causeSense;
    regRdData[SENSE_CTL_BIT]   = senseBusy;
    regRdData[IRQ_EN_BIT]      = irqEn;
    regRdData[PAGE_FIELD_W-1:0] = page;
  end

  assign irqOut  = status & irqEn;
  assign pageSel = page;

endmodule

// File: tb/irq_page_ctrl_tb_top.sv
module irq_page_ctrl_tb_top;

  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        gpioEvent;
  logic        senseEvent;
  logic        senseDone;
  logic        irqOut;
  logic        senseStart;
  logic        senseAbort;
  logic [3:0]  pageSel;

  int checks = 0;
  int errors = 0;

  // Expected state, derived from the requirements.
  logic       eStatus, eGpio, eSense, eBusy, eEn, eStart, eAbort;
  logic [3:0] ePage;

  always #5 clk = ~clk;

  irq_page_ctrl #(.NUM_PAGES(NP)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .gpioEvent  (gpioEvent),
    .senseEvent (senseEvent),
    .senseDone  (senseDone),
    .irqOut     (irqOut),
    .senseStart (senseStart),
    .senseAbort (senseAbort),
    .pageSel    (pageSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string req);
    logic [15:0] word;
    word = {eStatus, 1'b0, eGpio, eSense, eBusy, eEn, 6'b0, ePage};
    check(req, 32'(regRdData), 32'(word));
    check("R8 irq", 32'(irqOut), 32'(eStatus & eEn));
    check("R5 start", 32'(senseStart), 32'(eStart));
    check("R6 abort", 32'(senseAbort), 32'(eAbort));
    check("R9 page", 32'(pageSel), 32'(ePage));
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks after it.
  task automatic step(input logic wr, input logic [15:0] d, input logic g,
                      input logic s, input logic dn, input string req);
    logic fin, clr;
    regWrEn = wr; regWrData = d; gpioEvent = g; senseEvent = s; senseDone = dn;
    fin = dn & eBusy;
    clr = wr & d[15];
    eStart  = wr & d[11] & ~eBusy & ~fin;
    eAbort  = wr & ~d[11] & eBusy & ~fin;
    eStatus = (eStatus & ~clr) | g | s | fin;
    eGpio   = (eGpio & ~clr) | g;
    eSense  = (eSense & ~clr) | s | fin;
    eBusy   = fin ? 1'b0 : (wr ? d[11] : eBusy);
    if (wr) eEn = d[10];
    if (wr && int'(d[3:0]) < NP) ePage = d[3:0];
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; gpioEvent = 1'b0; senseEvent = 1'b0; senseDone = 1'b0;
    compareAll(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; regWrEn = 1'b0; regWrData = '0;
    gpioEvent = 1'b0; senseEvent = 1'b0; senseDone = 1'b0;
    {eStatus, eGpio, eSense, eBusy, eEn, eStart, eAbort} = '0;
    ePage = '0;
    repeat (3) @(negedge clk);
    compareAll("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R9: every page value, from each implemented starting page.
    for (int st = 0; st < NP; st++) begin
      for (int v = 0; v < 16; v++) begin
        step(1'b1, 16'(st), 1'b0, 1'b0, 1'b0, "R9 set");
        step(1'b1, 16'(v), 1'b0, 1'b0, 1'b0, "R9 probe");
        check("R9 mismatch", 32'(regRdData[3:0] != 4'(v)), 32'(v >= NP));
      end
    end

    // R2 R3 R4 R8: events, clear and enable in every combination.
    for (int pre = 0; pre < 4; pre++) begin
      for (int c = 0; c < 16; c++) begin
        step(1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, "R3 flush");
        step(1'b0, 16'h0000, pre[0], pre[1], 1'b0, "R2 preload");
        step(1'b1, {c[2], 4'b0, c[3], 10'b1}, c[0], c[1], 1'b0, "R4 collide");
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R8 hold");
      end
    end

    // R5 R6: launch, repeated launch, abort, idle zero write.
    step(1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, "R3 flush");
    step(1'b1, 16'h0800, 1'b0, 1'b0, 1'b0, "R5 launch");
    step(1'b1, 16'h0800, 1'b0, 1'b0, 1'b0, "R5 relaunch");
    step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R5 pulse ends");
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R6 abort");
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R6 idle zero");
    check("R6 no event", 32'(regRdData[15]), 32'd0);

    // R7: completion, completion racing writes, stray done while idle.
    step(1'b1, 16'h0C00, 1'b0, 1'b0, 1'b0, "R5 launch");
    step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, "R7 finish");
    step(1'b1, 16'h8800, 1'b0, 1'b0, 1'b0, "R5 launch after clear");
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, "R7 finish beats abort");
    step(1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, "R3 flush");
    step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, "R7 idle done ignored");
    step(1'b1, 16'h0800, 1'b0, 1'b0, 1'b0, "R5 launch");
    step(1'b1, 16'h0800, 1'b0, 1'b0, 1'b1, "R7 finish beats write one");
    step(1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, "R3 flush");

    // R10: reserved and read-only bits are not writable.
    step(1'b1, 16'h73F1, 1'b0, 1'b0, 1'b0, "R10 reserved");
    step(1'b1, 16'h73F0, 1'b0, 1'b0, 1'b0, "R10 reserved");
    check("R10 zero bits", 32'({regRdData[14:12], regRdData[9:4]}), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule